// File: doc/BRIEF.md
# Memory IO Connectivity Scan Chain

This block lets a tester confirm that the board wiring between a memory controller and a memory device is intact. Raising a level-sensitive scan-enable input puts a channel into scan mode. No test access port and no free-running clock are needed for entry. While scan mode is active, the block tells the command decoder to execute nothing and tells the IO ring to switch its terminations off. A scan clock edge with the capture select high latches the levels on every covered pin in parallel. Later scan clock edges with the select low move the captured word, one bit per edge, out of a single serial output.

The design models the device side, so it runs on an internal sampling clock. The scan clock, scan-enable and select inputs come from the board. They pass through a short synchronizer, and rising scan clock edges are detected after it. Each channel has its own control inputs, its own chain, its own serial output and its own error flag. The number of channels and the number of covered pins are parameters. A differential clock pair at the head of each chain must sit at opposite levels when it is captured. If both pins are equal at a capture, a sticky error flag is raised.

Each channel runs a three-state machine. ST_OFF is the state outside scan mode. ST_READY means scan mode is active and nothing has been captured yet. ST_LOADED means a capture has taken place. The transitions are: ST_OFF to ST_READY when the synchronized enable is high; ST_READY to ST_LOADED on a capture edge; ST_READY and ST_LOADED to ST_OFF when the synchronized enable is low. Power removal, modelled by the active-low reset, forces ST_OFF.

Top module: `scan_link_top`

## Requirements
- R1: After reset, every channel's serial output, command inhibit, termination-off and pair-error outputs are 0.
- R2: Command inhibit and termination-off for a channel go to 1 while its scan-enable is 1, with no clock edge needed. They return to 0 within 4 sampling-clock cycles after scan-enable falls.
- R3: A rising scan clock edge with capture select at 1 loads the chain with the word {pins, ck_c, ck_t}. Bit 0 is ck_t, bit 1 is ck_c, and bit 2+k is pin k. The serial output then shows bit 0.
- R4: A rising scan clock edge with capture select at 0 moves the chain one position toward the output. The serial output therefore presents ck_t, then ck_c, then pin 0 up to the last pin.
- R5: Each shift fills the far end of the chain with 0. After as many shifts as the chain has cells, the serial output is 0.
- R6: The serial output is 0 at any moment the channel's scan-enable is 0.
- R7: Leaving scan mode clears the chain. After re-entry and before any capture, the serial output is 0 on every shift.
- R8: A capture with ck_t equal to ck_c sets the pair-error flag. The flag stays set across later shifts and clears once scan mode is left.
- R9: A capture with ck_t and ck_c at opposite levels leaves the pair-error flag at 0.
- R10: Scan clock edges that arrive while scan-enable is 0 have no effect on the chain.
- R11: Channels are independent. Scan activity on one channel does not change another channel's chain, serial output or flags.
- R12: While reset (power removal) is active, all outputs are 0 even when scan-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset, models power removal |
| scan_en | input | NUM_CH | Per-channel scan-enable, level sensitive |
| scan_clk | input | NUM_CH | Per-channel scan clock, acts on the rising edge |
| cap_sel | input | NUM_CH | 1 = capture on the scan clock edge, 0 = shift |
| pin_lvl | input | NUM_CH*PINS | Covered pin levels, channel c in slice c*PINS |
| ck_t | input | NUM_CH | True pin of the differential clock pair |
| ck_c | input | NUM_CH | Complement pin of the differential clock pair |
| sout | output | NUM_CH | Serial scan output per channel |
| cmd_inhibit | output | NUM_CH | Tells the command decoder to execute nothing |
| term_off | output | NUM_CH | Switches on-die termination off |
| pair_err | output | NUM_CH | Sticky flag for a capture with an equal-level clock pair |

## Verification
On every cycle, the assertions check the following. The chain takes the captured word on a capture edge and moves one place with zero fill on a shift. The chain is empty outside scan mode. The pair-error flag holds while enabled and is low outside scan mode. The control outputs follow scan-enable. Only the bench scenarios can show the full serial bit order seen at the pin, and that edges during non-scan time are ignored. They also show that a cleared chain reads zero after re-entry, that the channels stay independent, and that reset overrides a high scan-enable.

// File: rtl/scan_link_pkg.sv
package scan_link_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_READY  = 2'd1,
        ST_LOADED = 2'd2
    } scan_state_t;

    // Bit positions inside the synchronized control bundle
    localparam int CTL_EN   = 0;
    localparam int CTL_SCLK = 1;
    localparam int CTL_CAP  = 2;
    localparam int CTL_W    = 3;

endpackage

// File: rtl/scan_in_sync.sv
module scan_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/scan_chan_ctrl.sv
module scan_chan_ctrl
    import scan_link_pkg::*;
#(
    parameter int PINS   = 10,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_raw,
    input  logic            sclk_raw,
    input  logic            cap_raw,
    input  logic [PINS-1:0] pins,
    input  logic            ck_t,
    input  logic            ck_c,
    output logic            sout,
    output logic            cmd_inhibit,
    output logic            term_off,
    output logic            pair_err
);
    localparam int CELLS = PINS + 2;

    scan_state_t       state, state_nx;
    logic [CTL_W-1:0]  ctl_s;
    logic              en_s, sclk_s, cap_s, sclk_d;
    logic              rise, cap_fire, shf_fire, active;
    logic [CELLS-1:0]  chain, cap_word;

    scan_in_sync #(.WIDTH(CTL_W), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cap_raw, sclk_raw, en_raw}),
        .q    (ctl_s)
    );

    assign en_s     = ctl_s[CTL_EN];
    assign sclk_s   = ctl_s[CTL_SCLK];
    assign cap_s    = ctl_s[CTL_CAP];
    assign rise     = sclk_s & ~sclk_d;
    assign cap_fire = rise & cap_s;
    assign shf_fire = rise & ~cap_s;
    assign active   = en_s && (state != ST_OFF);
    assign cap_word = {pins, ck_c, ck_t};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    if (en_s) state_nx = ST_READY;
            ST_READY: begin
                if (!en_s)         state_nx = ST_OFF;
                else if (cap_fire) state_nx = ST_LOADED;
            end
            ST_LOADED: if (!en_s) state_nx = ST_OFF;
            default:   state_nx = ST_OFF;
        endcase
    end

    // Chain, edge detector and pair-error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            chain    <= '0;
            pair_err <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (!active) begin
                chain    <= '0;
                pair_err <= 1'b0;
            end else if (cap_fire) begin
                chain <= cap_word;
                if (ck_t == ck_c) pair_err <= 1'b1;
            end else if (shf_fire) begin
                chain <= {1'b0, chain[CELLS-1:1]};
            end
        end
    end

    // Output logic
    always_comb begin
        cmd_inhibit = rst_n && (en_raw || (state != ST_OFF));
        term_off    = cmd_inhibit;
        sout        = rst_n && en_raw && (state != ST_OFF) && chain[0];
    end

    assert_capture_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && active) |=> (chain == $past(cap_word)));

    assert_shift_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_fire && active) |=> (chain[CELLS-2:0] == $past(chain[CELLS-1:1])));

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_fire && active) |=> !chain[CELLS-1]);

    assert_chain_empty_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (chain == '0));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_err && en_s) |=> pair_err);

    assert_err_off_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !pair_err);

    assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/scan_link_top.sv
module scan_link_top #(
    parameter int NUM_CH = 2,
    parameter int PINS   = 10,
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      scan_en,
    input  logic [NUM_CH-1:0]      scan_clk,
    input  logic [NUM_CH-1:0]      cap_sel,
    input  logic [NUM_CH*PINS-1:0] pin_lvl,
    input  logic [NUM_CH-1:0]      ck_t,
    input  logic [NUM_CH-1:0]      ck_c,
    output logic [NUM_CH-1:0]      sout,
    output logic [NUM_CH-1:0]      cmd_inhibit,
    output logic [NUM_CH-1:0]      term_off,
    output logic [NUM_CH-1:0]      pair_err
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        scan_chan_ctrl #(.PINS(PINS), .STAGES(STAGES)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_raw     (scan_en[g]),
            .sclk_raw   (scan_clk[g]),
            .cap_raw    (cap_sel[g]),
            .pins       (pin_lvl[g*PINS +: PINS]),
            .ck_t       (ck_t[g]),
            .ck_c       (ck_c[g]),
            .sout       (sout[g]),
            .cmd_inhibit(cmd_inhibit[g]),
            .term_off   (term_off[g]),
            .pair_err   (pair_err[g])
        );

        assert_ctrl_follow_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
            scan_en[g] |-> (cmd_inhibit[g] && term_off[g]));

        assert_sout_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !scan_en[g] |-> !sout[g]);
    end
endmodule

// File: tb/scan_link_top_tb_top.sv
module scan_link_top_tb_top;
    localparam int NUM_CH = 2;
    localparam int PINS   = 10;
    localparam int CELLS  = PINS + 2;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [NUM_CH-1:0]      scan_en, scan_clk, cap_sel, ck_t, ck_c;
    logic [NUM_CH*PINS-1:0] pin_lvl;
    logic [NUM_CH-1:0]      sout, cmd_inhibit, term_off, pair_err;

    always #5 clk = ~clk;

    scan_link_top #(.NUM_CH(NUM_CH), .PINS(PINS), .STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_clk(scan_clk),
        .cap_sel(cap_sel), .pin_lvl(pin_lvl), .ck_t(ck_t), .ck_c(ck_c),
        .sout(sout), .cmd_inhibit(cmd_inhibit), .term_off(term_off),
        .pair_err(pair_err)
    );

    // kind: 0 = sout, 1 = cmd_inhibit, 2 = term_off, 3 = pair_err
    typedef struct {
        int    ch;
        int    kind;
        logic  val;
        string tag;
    } exp_t;

    exp_t queue_q[$];
    event chk_ev;
    int   compared   = 0;
    int   mismatched = 0;
    bit   done       = 1'b0;

    function automatic logic observe(int ch, int kind);
        case (kind)
            0:       return sout[ch];
            1:       return cmd_inhibit[ch];
            2:       return term_off[ch];
            default: return pair_err[ch];
        endcase
    endfunction

    // Monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (queue_q.size() > 0) begin
                exp_t e;
                logic got;
                e   = queue_q.pop_front();
                got = observe(e.ch, e.kind);
                compared++;
                if (got !== e.val) begin
                    mismatched++;
                    $display("FAIL %s ch%0d kind%0d actual=%b expected=%b",
                             e.tag, e.ch, e.kind, got, e.val);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(int ch, int kind, logic v, string tag);
        exp_t e;
        e.ch = ch; e.kind = kind; e.val = v; e.tag = tag;
        queue_q.push_back(e);
        #1;
        -> chk_ev;
        #1;
    endtask

    task automatic scan_pulse(int ch, logic cap);
        cap_sel[ch] = cap;
        tick(2);
        scan_clk[ch] = 1'b1;
        tick(4);
        scan_clk[ch] = 1'b0;
        tick(4);
    endtask

    function automatic logic [CELLS-1:0] word_of(int ch);
        return {pin_lvl[ch*PINS +: PINS], ck_c[ch], ck_t[ch]};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [CELLS-1:0] w0, w1;
        rst_n = 1'b0; scan_en = '0; scan_clk = '0; cap_sel = '0;
        ck_t = '0; ck_c = '0; pin_lvl = '0;
        tick(2);
        // R12: power removal overrides a high scan-enable
        scan_en[0] = 1'b1;
        tick(2);
        expect_val(0, 1, 1'b0, "R12");
        expect_val(0, 2, 1'b0, "R12");
        expect_val(0, 0, 1'b0, "R12");
        scan_en[0] = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(3);
        // R1: reset state
        for (int c = 0; c < NUM_CH; c++)
            for (int k = 0; k < 4; k++) expect_val(c, k, 1'b0, "R1");

        // R2: immediate inhibit on entry
        scan_en[0] = 1'b1;
        expect_val(0, 1, 1'b1, "R2");
        expect_val(0, 2, 1'b1, "R2");
        expect_val(1, 1, 1'b0, "R11");
        tick(5);

        // R3, R4, R5, R9: legal capture then full shift-out
        pin_lvl[0 +: PINS] = 10'b1011001110;
        ck_t[0] = 1'b1; ck_c[0] = 1'b0;
        w0 = word_of(0);
        scan_pulse(0, 1'b1);
        expect_val(0, 0, w0[0], "R3");
        expect_val(0, 3, 1'b0, "R9");
        for (int i = 1; i < CELLS; i++) begin
            scan_pulse(0, 1'b0);
            expect_val(0, 0, w0[i], "R4");
        end
        scan_pulse(0, 1'b0);
        expect_val(0, 0, 1'b0, "R5");
        scan_pulse(0, 1'b0);
        expect_val(0, 0, 1'b0, "R5");

        // R8: equal clock pair sets the sticky flag
        pin_lvl[0 +: PINS] = 10'b1111111111;
        ck_t[0] = 1'b1; ck_c[0] = 1'b1;
        scan_pulse(0, 1'b1);
        expect_val(0, 3, 1'b1, "R8");
        scan_pulse(0, 1'b0);
        scan_pulse(0, 1'b0);
        expect_val(0, 3, 1'b1, "R8");
        expect_val(0, 0, 1'b1, "R4");
        // R6: output forced low at once on exit
        scan_en[0] = 1'b0;
        expect_val(0, 0, 1'b0, "R6");
        tick(6);
        expect_val(0, 3, 1'b0, "R8");
        expect_val(0, 1, 1'b0, "R2");
        expect_val(0, 2, 1'b0, "R2");

        // R10: edges while disabled are ignored
        ck_t[0] = 1'b1; ck_c[0] = 1'b0;
        scan_pulse(0, 1'b1);
        scan_pulse(0, 1'b1);
        expect_val(0, 0, 1'b0, "R6");
        scan_en[0] = 1'b1;
        tick(5);
        expect_val(0, 0, 1'b0, "R10");
        expect_val(0, 3, 1'b0, "R10");
        // R7: chain was cleared on exit
        for (int i = 0; i < 3; i++) begin
            scan_pulse(0, 1'b0);
            expect_val(0, 0, 1'b0, "R7");
        end

        // R11: independent channels
        scan_en[1] = 1'b1;
        tick(5);
        pin_lvl[0 +: PINS]    = 10'b0101010101;
        ck_t[0] = 1'b1; ck_c[0] = 1'b0;
        w0 = word_of(0);
        scan_pulse(0, 1'b1);
        pin_lvl[PINS +: PINS] = 10'b0011100101;
        ck_t[1] = 1'b0; ck_c[1] = 1'b1;
        w1 = word_of(1);
        scan_pulse(1, 1'b1);
        expect_val(1, 0, w1[0], "R11");
        expect_val(1, 3, 1'b0, "R9");
        expect_val(0, 0, w0[0], "R11");
        scan_pulse(0, 1'b0);
        expect_val(0, 0, w0[1], "R11");
        expect_val(1, 0, w1[0], "R11");
        scan_pulse(1, 1'b0);
        expect_val(1, 0, w1[1], "R11");
        expect_val(0, 0, w0[1], "R11");
        scan_pulse(1, 1'b0);
        expect_val(1, 0, w1[2], "R4");
        scan_en[1] = 1'b0;
        expect_val(1, 0, 1'b0, "R6");
        expect_val(0, 1, 1'b1, "R11");
        tick(6);
        expect_val(1, 1, 1'b0, "R2");

        done = 1'b1;
        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule